// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Resolver

This block takes one interrupt command issued by one of N local interrupt units and works out which of the N units must accept it. Each target unit presents its physical ID, its logical ID and its logical format (flat or cluster). The command carries a destination byte, a physical/logical select, a two-bit shorthand that can override the destination, and a delivery mode.

For every delivery mode except lowest priority, the result is the bitmap of all matching targets. For lowest-priority delivery, one target is chosen by rotating round-robin among the matching targets whose enable input is high. The result is registered and appears one cycle after the command strobe, together with a one-cycle valid pulse. Vector queuing and the per-target state machines sit outside this block.

Top module: `ipi_dest_resolver`

## Requirements
- R1: After rst_ni is asserted, hit_valid_o is 0 and hit_mask_o is all zeros. The round-robin pointer rests on target N-1, so the first lowest-priority search begins at target 0.
- R2: A command sampled with cmd_valid_i high at a rising edge gives hit_valid_o = 1 and its hit_mask_o right after that edge, for exactly one cycle. In a cycle that follows an edge with no command, hit_valid_o is 0 and hit_mask_o is zero.
- R3: Shorthand cmd_lo_i[19:18] = 1 (self) selects only the target whose index equals src_i. Destination and mode fields are disregarded.
- R4: Shorthand 2 (all) selects every target.
- R5: Shorthand 3 (others) selects every target except src_i.
- R6: With shorthand 0 and cmd_lo_i[11] = 0 (physical), a target matches when cmd_hi_i[31:24] equals its physical ID. A destination of 0xFF matches every target.
- R7: With shorthand 0 and cmd_lo_i[11] = 1 (logical), a target with format 0 (flat) matches when its logical ID ANDed with the destination is nonzero.
- R8: In logical mode, a target with format 1 (cluster) matches when the upper nibble of its logical ID equals the upper nibble of the destination and the lower nibbles ANDed together are nonzero.
- R9: In logical mode, a target with format 2 or 3 never matches.
- R10: With delivery mode cmd_lo_i[10:8] = 3'b001 (lowest priority), at most one target is set. The search begins at the target after the pointer, wraps around, and takes the first target that is both matched and enabled (tgt_en_i). The pointer then moves to that target.
- R11: In lowest-priority mode, if no matched target is enabled, hit_mask_o is zero and the pointer does not move.
- R12: In any other delivery mode, tgt_en_i has no effect, and hit_mask_o is the full set of matching targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_lo_i | input | 32 | Command low word: shorthand, physical/logical select, delivery mode, vector |
| cmd_hi_i | input | 32 | Command high word; destination in bits 31:24 |
| src_i | input | $clog2(N_TGT) | Index of the issuing unit |
| tgt_phys_id_i | input | N_TGT*ID_W | Physical ID of each target, target g at bits g*ID_W upward |
| tgt_log_id_i | input | N_TGT*ID_W | Logical ID of each target |
| tgt_fmt_i | input | N_TGT*2 | Logical format of each target (0 flat, 1 cluster, 2 and 3 invalid) |
| tgt_en_i | input | N_TGT | Target enable, used only for lowest-priority delivery |
| hit_valid_o | output | 1 | One-cycle result strobe |
| hit_mask_o | output | N_TGT | Bitmap of accepting targets |

## Verification
The round-robin wrap is the hardest case to reach from the ports. To see it, the pointer has to sit near the top index while the only enabled candidates lie below it. A miss must also leave the pointer in place, and a miss leaves no trace on the outputs.

The stimulus therefore issues a fixed sequence of lowest-priority commands, starting from reset, with chosen enable patterns. This walks the pointer to target 7 and then forces a wrap to target 5. After that, it inserts a command with no enabled candidate and shows that the following pick resumes from the preserved pointer. Finally, a command with a physical destination moves the pointer to a chosen point before an all-target search.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef enum logic [1:0] {
    FMT_FLAT    = 2'd0,
    FMT_CLUSTER = 2'd1
  } lfmt_e;

  localparam int unsigned SH_LSB   = 18;
  localparam int unsigned LOG_BIT  = 11;
  localparam int unsigned DLV_LSB  = 8;
  localparam int unsigned DLV_W    = 3;
  localparam int unsigned DEST_LSB = 24;
  localparam logic [DLV_W-1:0] DLV_LOWEST = 3'b001;
endpackage

// File: rtl/ipi_addr_match.sv
module ipi_addr_match
  import ipi_pkg::*;
#(
  parameter int unsigned ID_W = 8
) (
  input  logic [ID_W-1:0] dest_i,
  input  logic            logical_i,
  input  logic [ID_W-1:0] phys_id_i,
  input  logic [ID_W-1:0] log_id_i,
  input  logic [1:0]      fmt_i,
  output logic            hit_o
);
  localparam int unsigned HALF = ID_W / 2;

  logic phys_hit, flat_hit, clus_hit;

  assign phys_hit = (dest_i == phys_id_i) || (dest_i == {ID_W{1'b1}});
  assign flat_hit = |(dest_i & log_id_i);
  assign clus_hit = (dest_i[ID_W-1:HALF] == log_id_i[ID_W-1:HALF]) &&
                    (|(dest_i[HALF-1:0] & log_id_i[HALF-1:0]));

  always_comb begin
    if (!logical_i) hit_o = phys_hit;
    else begin
      case (fmt_i)
        FMT_FLAT:    hit_o = flat_hit;
        FMT_CLUSTER: hit_o = clus_hit;
        default:     hit_o = 1'b0;   // undefined format matches nothing
      endcase
    end
  end
endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int unsigned N_TGT = 8,
  localparam int unsigned PW   = $clog2(N_TGT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_TGT-1:0] cand_i,
  input  logic             advance_i,
  output logic [N_TGT-1:0] pick_o
);
  logic [PW-1:0] ptr_q, sel;
  logic          found;

  // first candidate strictly after ptr_q, wrapping; ptr_q itself checked last
  always_comb begin
    pick_o = '0;
    found  = 1'b0;
    sel    = ptr_q;
    for (int k = 1; k <= int'(N_TGT); k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % int'(N_TGT);
      if (!found && cand_i[idx]) begin
        found       = 1'b1;
        pick_o[idx] = 1'b1;
        sel         = PW'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ptr_q <= PW'(N_TGT - 1);
    else if (advance_i && found) ptr_q <= sel;
  end

  assert_pick_subset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pick_o) && ((pick_o & ~cand_i) == '0));

  assert_ptr_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && cand_i == '0) |=> $stable(ptr_q));
endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
  import ipi_pkg::*;
#(
  parameter int unsigned N_TGT = 8,
  parameter int unsigned ID_W  = 8,
  localparam int unsigned SW   = $clog2(N_TGT)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic [31:0]           cmd_lo_i,
  input  logic [31:0]           cmd_hi_i,
  input  logic [SW-1:0]         src_i,
  input  logic [N_TGT*ID_W-1:0] tgt_phys_id_i,
  input  logic [N_TGT*ID_W-1:0] tgt_log_id_i,
  input  logic [N_TGT*2-1:0]    tgt_fmt_i,
  input  logic [N_TGT-1:0]      tgt_en_i,
  output logic                  hit_valid_o,
  output logic [N_TGT-1:0]      hit_mask_o
);
  shorthand_e       sh;
  logic             logical, lowest;
  logic [ID_W-1:0]  dest;
  logic [N_TGT-1:0] match_vec, pick, mask_d;

  assign sh      = shorthand_e'(cmd_lo_i[SH_LSB +: 2]);
  assign logical = cmd_lo_i[LOG_BIT];
  assign lowest  = (cmd_lo_i[DLV_LSB +: DLV_W] == DLV_LOWEST);
  assign dest    = cmd_hi_i[DEST_LSB +: ID_W];

  for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
    logic addr_hit;
    ipi_addr_match #(.ID_W(ID_W)) u_match (
      .dest_i    (dest),
      .logical_i (logical),
      .phys_id_i (tgt_phys_id_i[g*ID_W +: ID_W]),
      .log_id_i  (tgt_log_id_i[g*ID_W +: ID_W]),
      .fmt_i     (tgt_fmt_i[g*2 +: 2]),
      .hit_o     (addr_hit)
    );
    assign match_vec[g] = (sh == SH_NONE)   ? addr_hit :
                          (sh == SH_SELF)   ? (src_i == SW'(g)) :
                          (sh == SH_ALL)    ? 1'b1 :
                                              (src_i != SW'(g));
  end

  ipi_rr_pick #(.N_TGT(N_TGT)) u_rr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cand_i    (match_vec & tgt_en_i),
    .advance_i (cmd_valid_i && lowest),
    .pick_o    (pick)
  );

  assign mask_d = lowest ? pick : match_vec;

  logic       lp_q;
  shorthand_e sh_q;
  logic [SW-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_valid_o <= 1'b0;
      hit_mask_o  <= '0;
      lp_q        <= 1'b0;
      sh_q        <= SH_NONE;
      src_q       <= '0;
    end else begin
      hit_valid_o <= cmd_valid_i;
      hit_mask_o  <= cmd_valid_i ? mask_d : '0;
      lp_q        <= lowest;
      sh_q        <= sh;
      src_q       <= src_i;
    end
  end

  assert_valid_next_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> hit_valid_o);

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> (!hit_valid_o && hit_mask_o == '0));

  assert_self_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_valid_o && sh_q == SH_SELF) |-> (hit_mask_o == (N_TGT'(1) << src_q)));

  assert_excl_self_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_valid_o && sh_q == SH_OTHERS) |-> !hit_mask_o[src_q]);

  assert_lp_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_valid_o && lp_q) |-> $onehot0(hit_mask_o));
endmodule

// File: tb/tb_ipi_dest_resolver.sv
module tb_ipi_dest_resolver;
  localparam int N = 8;
  localparam int W = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [31:0]   cmd_lo = '0, cmd_hi = '0;
  logic [2:0]    src = '0;
  logic [N*W-1:0] phys_id, log_id;
  logic [N*2-1:0] fmt;
  logic [N-1:0]   en;
  logic          hit_valid;
  logic [N-1:0]  hit_mask;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ipi_dest_resolver #(.N_TGT(N), .ID_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid),
    .cmd_lo_i(cmd_lo), .cmd_hi_i(cmd_hi), .src_i(src),
    .tgt_phys_id_i(phys_id), .tgt_log_id_i(log_id), .tgt_fmt_i(fmt),
    .tgt_en_i(en), .hit_valid_o(hit_valid), .hit_mask_o(hit_mask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lo(input int sh, input int lg, input int dlv);
    return (32'(sh) << 18) | (32'(lg) << 11) | (32'(dlv) << 8) | 32'h31;
  endfunction

  // one command; result checked the cycle after the strobe, idle the cycle after that
  task automatic send(input string req, input logic [31:0] l, input logic [7:0] d,
                      input logic [2:0] s, input logic [N-1:0] exp);
    @(negedge clk);
    cmd_lo = l; cmd_hi = {d, 24'h0}; src = s; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({req, " valid"}, 32'(hit_valid), 32'd1);
    chk({req, " mask"}, 32'(hit_mask), 32'(exp));
    @(negedge clk);
    chk("R2 idle", {31'd0, hit_valid} | 32'(hit_mask), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 valid", 32'(hit_valid), 32'd0);
    chk("R1 mask", 32'(hit_mask), 32'd0);
  endtask

  task automatic t_physical;
    fmt = '0;
    send("R6 exact", lo(0, 0, 0), 8'h13, 3'd0, 8'h08);
    send("R6 broadcast", lo(0, 0, 0), 8'hFF, 3'd0, 8'hFF);
    send("R6 none", lo(0, 0, 0), 8'h55, 3'd0, 8'h00);
  endtask

  task automatic t_flat;
    fmt = '0;
    for (int i = 0; i < N; i++) log_id[i*W +: W] = 8'(1 << i);
    send("R7 flat", lo(0, 1, 0), 8'h05, 3'd0, 8'h05);
    send("R7 flat high", lo(0, 1, 0), 8'hC0, 3'd0, 8'hC0);
  endtask

  task automatic t_cluster;
    for (int i = 0; i < N; i++) begin
      fmt[i*2 +: 2] = 2'd1;
      log_id[i*W +: W] = {4'(i >> 2), 4'(1 << (i & 3))};
    end
    send("R8 cluster1", lo(0, 1, 0), 8'h13, 3'd0, 8'h30);
    send("R8 cluster0", lo(0, 1, 0), 8'h0C, 3'd0, 8'h0C);
    send("R8 wrong cluster", lo(0, 1, 0), 8'h20, 3'd0, 8'h00);
    fmt[4 +: 2] = 2'd2;
    fmt[6 +: 2] = 2'd3;
    send("R9 bad format", lo(0, 1, 0), 8'h0F, 3'd0, 8'h03);
  endtask

  task automatic t_shorthand;
    send("R3 self", lo(1, 1, 0), 8'h00, 3'd5, 8'h20);
    send("R4 all", lo(2, 0, 0), 8'h00, 3'd5, 8'hFF);
    send("R5 others", lo(3, 0, 0), 8'h13, 3'd5, 8'hDF);
  endtask

  task automatic t_en_ignored;
    en = '0;
    send("R12 fixed all en off", lo(2, 0, 0), 8'h00, 3'd0, 8'hFF);
    send("R12 fixed phys en off", lo(0, 0, 0), 8'h16, 3'd0, 8'h40);
  endtask

  task automatic t_lowest;
    en = '1;
    send("R10 first from reset", lo(2, 0, 1), 8'h00, 3'd0, 8'h01);
    send("R10 rotate", lo(2, 0, 1), 8'h00, 3'd0, 8'h02);
    en = 8'b1010_0000;
    send("R10 skip disabled", lo(2, 0, 1), 8'h00, 3'd0, 8'h20);
    send("R10 next enabled", lo(2, 0, 1), 8'h00, 3'd0, 8'h80);
    send("R10 wrap", lo(2, 0, 1), 8'h00, 3'd0, 8'h20);
    en = '0;
    send("R11 none enabled", lo(2, 0, 1), 8'h00, 3'd0, 8'h00);
    en = '1;
    send("R11 pointer kept", lo(2, 0, 1), 8'h00, 3'd0, 8'h40);
    send("R10 phys single", lo(0, 0, 1), 8'h13, 3'd0, 8'h08);
    send("R10 after phys", lo(2, 0, 1), 8'h00, 3'd0, 8'h10);
  endtask

  initial begin
    for (int i = 0; i < N; i++) phys_id[i*W +: W] = 8'(8'h10 + i);
    log_id = '0; fmt = '0; en = '1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lowest();
    t_physical();
    t_flat();
    t_cluster();
    t_shorthand();
    t_en_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule